// File: doc/BRIEF.md
# Fixed Off-Time Current Chopper

This block limits the current in one winding of a three-phase bridge. While the PWM enable is high it turns on the high-side driver that the commutation logic has selected. The winding current then rises until an external sense comparator reports that the limit is reached. That trip clears the source-enable latch, and the high side stays off for a programmed number of clock cycles while the load current recirculates. Afterwards the selected high side turns on again. Every turn-on starts a blanking window. Inside that window the comparator is not looked at, so the reverse-recovery spike that follows switching cannot end the on-phase early.

The trip input comes from an analog comparator, so it passes through a two-flop synchronizer before the controller uses it. The blank length and the off length are register inputs counted in clock cycles. Each one is sampled on the clock edge that starts its interval. The controller has four states. `ST_IDLE` means PWM is low. `ST_BLANK` means the source is on and the trip is masked. `ST_SENSE` means the source is on and the trip is watched. `ST_OFF` is the fixed off period. The transitions are:

- IDLE→BLANK when PWM rises.
- BLANK→SENSE when the blank count runs out.
- SENSE→OFF on a synchronized trip.
- OFF→BLANK when the off count runs out.
- Any state→IDLE when PWM is low.

Reset leaves the controller in BLANK.

Top module: `offtime_chopper`

## Requirements
- R1: While `rst` is high, `src_en` and `hs_gate` are 0. After reset the controller is in the blanking state, so with `pwm_en` high `src_en` is 1 in the first cycle after release.
- R2: When `pwm_en` is low, `src_en` and `hs_gate` are 0 in that same cycle. The controller enters IDLE on the next edge.
- R3: `hs_gate` equals `hs_sel` when `src_en` is 1 and is all zeros otherwise. Bit i of `hs_gate` drives phase i.
- R4: `trip_raw` is delayed by two synchronizer flops. In SENSE, a trip that is first sampled at edge e turns `src_en` off after edge e+2.
- R5: After each turn-on, `src_en` stays 1 and trips are ignored for max(`blank_cycles`,1) cycles.
- R6: A trip taken in SENSE holds `src_en` at 0 for exactly max(`off_cycles`,1) cycles. The source then turns on again with a new blank window.
- R7: SENSE always lasts at least one cycle. With the trip held high continuously, each on-phase lasts max(`blank_cycles`,1)+1 cycles.
- R8: `blank_cycles` and `off_cycles` are sampled only on the edge that starts their interval. A change during an interval affects the next interval only.
- R9: A rise of `pwm_en` moves IDLE to BLANK, so `src_en` is 0 in the cycle where `pwm_en` first reads 1 and is 1 from the next cycle on. A PWM drop during an off period abandons that period.
- R10: Trips that arrive during an off period neither extend nor shorten it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_en | input | 1 | PWM enable; low forces the source off |
| trip_raw | input | 1 | Sense comparator output, asynchronous |
| hs_sel | input | PHASES | One-hot high-side selection from commutation |
| blank_cycles | input | CNT_W | Blank window length in clock cycles |
| off_cycles | input | CNT_W | Fixed off-time in clock cycles |
| src_en | output | 1 | Source-enable latch state |
| hs_gate | output | PHASES | Gated high-side drive, hs_sel masked by src_en |

## Verification
The assertions assume that reset is held for at least as many cycles as there are synchronizer stages, so that the pipeline holds known values when checking begins. They also assume that `pwm_en`, `blank_cycles` and `off_cycles` change only between clock edges. The bench meets both assumptions by holding reset for three cycles and by driving every input two nanoseconds after a rising edge. It compares each cycle against a behavioural model. Trips are placed deliberately inside blank windows, inside off periods and in the steady sensing state, which exercises each transition guard.

// File: rtl/chop_pkg.sv
package chop_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BLANK = 2'd1,
        ST_SENSE = 2'd2,
        ST_OFF   = 2'd3
    } chop_state_e;

endpackage

// File: rtl/chop_sync.sv
module chop_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[0] <= 1'b0;
                    else     chain_q[0] <= din;
                end
            end else begin : g_rest
                always_ff @(posedge clk) begin
                    if (rst) chain_q[g] <= 1'b0;
                    else     chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign dout = chain_q[STAGES-1];

    // R4
    sync_latency_chk: assert property (@(posedge clk) disable iff (rst)
        dout |-> $past(din, STAGES));

endmodule

// File: rtl/chop_interval.sv
module chop_interval #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         last
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (load)              cnt_q <= load_val;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign last = (cnt_q[W-1:1] == '0);

    // R8
    count_down_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q - 1'b1)));

endmodule

// File: rtl/chop_fsm.sv
module chop_fsm
    import chop_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic pwm_en,
    input  logic trip_s,
    input  logic cnt_last,
    output logic load_blank,
    output logic load_off,
    output logic src_on
);

    chop_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_BLANK;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (!pwm_en) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_BLANK;
                ST_BLANK: if (cnt_last) state_d = ST_SENSE;
                ST_SENSE: if (trip_s)   state_d = ST_OFF;
                ST_OFF:   if (cnt_last) state_d = ST_BLANK;
            endcase
        end
    end

    always_comb begin
        src_on     = !rst && pwm_en &&
                     (state_q == ST_BLANK || state_q == ST_SENSE);
        load_blank = (state_d == ST_BLANK) && (state_q != ST_BLANK);
        load_off   = (state_d == ST_OFF)   && (state_q != ST_OFF);
    end

    // R2
    idle_on_pwm_low_chk: assert property (@(posedge clk) disable iff (rst)
        !pwm_en |=> (state_q == ST_IDLE));

    // R5
    blank_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_BLANK && !cnt_last && pwm_en) |=> (state_q == ST_BLANK));

    // R6
    off_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_OFF && !cnt_last && pwm_en) |=> (state_q == ST_OFF));

    // R7
    sense_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_BLANK) |=> (state_q != ST_OFF));

    // R9
    rearm_blank_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && pwm_en) |=> (state_q == ST_BLANK));

endmodule

// File: rtl/offtime_chopper.sv
module offtime_chopper
    import chop_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int PHASES      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pwm_en,
    input  logic              trip_raw,
    input  logic [PHASES-1:0] hs_sel,
    input  logic [CNT_W-1:0]  blank_cycles,
    input  logic [CNT_W-1:0]  off_cycles,
    output logic              src_en,
    output logic [PHASES-1:0] hs_gate
);

    logic             trip_s;
    logic             cnt_last;
    logic             load_blank;
    logic             load_off;
    logic             src_on;
    logic             cnt_load;
    logic [CNT_W-1:0] cnt_val;

    chop_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (trip_raw),
        .dout (trip_s)
    );

    assign cnt_load = rst || load_blank || load_off;
    assign cnt_val  = (load_off && !rst) ? off_cycles : blank_cycles;

    chop_interval #(.W(CNT_W)) u_interval (
        .clk      (clk),
        .rst      (rst),
        .load     (cnt_load),
        .load_val (cnt_val),
        .last     (cnt_last)
    );

    chop_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .pwm_en     (pwm_en),
        .trip_s     (trip_s),
        .cnt_last   (cnt_last),
        .load_blank (load_blank),
        .load_off   (load_off),
        .src_on     (src_on)
    );

    assign src_en  = src_on;
    assign hs_gate = hs_sel & {PHASES{src_on}};

endmodule

// File: tb/offtime_chopper_bench.sv
`timescale 1ns/1ps
module offtime_chopper_bench;

    localparam int CW = 16;
    localparam int PH = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pwm_en = 1'b0;
    logic          trip_raw = 1'b0;
    logic [PH-1:0] hs_sel = 3'b001;
    logic [CW-1:0] blank_cycles = 16'd4;
    logic [CW-1:0] off_cycles = 16'd6;
    logic          src_en;
    logic [PH-1:0] hs_gate;

    offtime_chopper #(.CNT_W(CW), .PHASES(PH), .SYNC_STAGES(2)) u_offtime_chopper (
        .clk(clk), .rst(rst), .pwm_en(pwm_en), .trip_raw(trip_raw),
        .hs_sel(hs_sel), .blank_cycles(blank_cycles), .off_cycles(off_cycles),
        .src_en(src_en), .hs_gate(hs_gate)
    );

    always #5 clk = ~clk;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // behavioural model: 0 idle, 1 masked-on, 2 watching-on, 3 off
    int m_mode = 1;
    int m_left = 0;
    bit m_p1 = 1'b0, m_p2 = 1'b0;

    task automatic check(input string req, input int got, input int exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, got, exp, $time);
        end
    endtask

    function automatic int atleast1(input int v);
        return (v < 1) ? 1 : v;
    endfunction

    always @(negedge clk) begin
        if (!done) begin
            bit exp_on;
            bit seen;
            exp_on = pwm_en && !rst && (m_mode == 1 || m_mode == 2);
            check(cur_req, int'(src_en), int'(exp_on));
            check("R3", int'(hs_gate), exp_on ? int'(hs_sel) : 0);
            if (rst) begin
                m_mode = 1; m_left = int'(blank_cycles); m_p1 = 0; m_p2 = 0;
            end else begin
                seen = m_p2;
                m_p2 = m_p1;
                m_p1 = trip_raw;
                if (!pwm_en) m_mode = 0;
                else if (m_mode == 0) begin
                    m_mode = 1; m_left = int'(blank_cycles);
                end else if (m_mode == 1) begin
                    if (m_left <= 1) m_mode = 2; else m_left--;
                end else if (m_mode == 2) begin
                    if (seen) begin m_mode = 3; m_left = int'(off_cycles); end
                end else begin
                    if (m_left <= 1) begin m_mode = 1; m_left = int'(blank_cycles); end
                    else m_left--;
                end
            end
        end
    end

    task automatic go();
        @(posedge clk); #2;
    endtask

    task automatic wait_rise();
        @(negedge clk);
        while (src_en) @(negedge clk);
        while (!src_en) @(negedge clk);
    endtask

    task automatic wait_fall();
        @(negedge clk);
        while (!src_en) @(negedge clk);
        while (src_en) @(negedge clk);
    endtask

    task automatic measure(output int on_len, output int off_len);
        wait_rise();
        on_len = 0;
        while (src_en) begin on_len++; @(negedge clk); end
        off_len = 0;
        while (!src_en) begin off_len++; @(negedge clk); end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog (all requirements): actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        int on_len, off_len, rest, cnt;
        logic [31:0] lf;
        // R1: reset holds output off, then starts blanked
        cur_req = "R1";
        pwm_en = 1; trip_raw = 1;
        repeat (3) go();
        rst = 0;
        @(negedge clk);
        check("R1", int'(src_en), 1);
        measure(on_len, off_len);
        check("R7", on_len, 4 + 1);
        check("R6", off_len, 6);

        // R5 / R6 zero lengths act as one cycle
        cur_req = "R5";
        go(); blank_cycles = 0; off_cycles = 0;
        measure(on_len, off_len);
        measure(on_len, off_len);
        check("R5", on_len, atleast1(0) + 1);
        check("R6", off_len, atleast1(0));

        // R8 sampling at interval start
        cur_req = "R8";
        go(); blank_cycles = 3; off_cycles = 5;
        measure(on_len, off_len);
        wait_rise();
        go(); blank_cycles = 10; off_cycles = 20;
        rest = 0;
        @(negedge clk);
        while (src_en) begin rest++; @(negedge clk); end
        off_len = 0;
        while (!src_en) begin off_len++; @(negedge clk); end
        check("R8", rest, 3);
        check("R8", off_len, 20);
        on_len = 0;
        while (src_en) begin on_len++; @(negedge clk); end
        check("R8", on_len, 11);

        // R10 pulse during off does not change it
        cur_req = "R10";
        wait_fall();
        off_len = 1;
        for (int i = 1; i <= 60; i++) begin
            go();
            trip_raw = (i == 5);
            @(negedge clk);
            if (src_en) break;
            off_len++;
        end
        check("R10", off_len, 20);

        // R4 synchronizer latency from steady sensing
        cur_req = "R4";
        go(); blank_cycles = 4; off_cycles = 6;
        repeat (20) go();
        check("R4", int'(src_en), 1);
        go(); trip_raw = 1;
        cnt = 0;
        @(negedge clk);
        while (src_en) begin cnt++; @(negedge clk); end
        check("R4", cnt, 3);

        // R5 trip pulse inside the blank window is ignored
        cur_req = "R5";
        go(); trip_raw = 0; blank_cycles = 6;
        wait_rise();
        go(); trip_raw = 1;
        go(); trip_raw = 0;
        repeat (20) go();
        @(negedge clk);
        check("R5", int'(src_en), 1);

        // R2 / R9 PWM drop in off, then re-arm
        cur_req = "R9";
        go(); trip_raw = 1;
        wait_fall();
        go(); pwm_en = 0;
        @(negedge clk);
        check("R2", int'(src_en), 0);
        check("R2", int'(hs_gate), 0);
        repeat (4) go();
        trip_raw = 0;
        go(); pwm_en = 1;
        @(negedge clk);
        check("R9", int'(src_en), 0);
        @(negedge clk);
        check("R9", int'(src_en), 1);
        cur_req = "R2";
        go(); pwm_en = 0;
        @(negedge clk);
        check("R2", int'(src_en), 0);
        go(); pwm_en = 1;

        // R3 phase selection with pseudo-random trips
        cur_req = "R3";
        go(); blank_cycles = 3; off_cycles = 4;
        lf = 32'h0000_1d2b;
        for (int i = 0; i < 300; i++) begin
            go();
            lf = lf * 32'd1103515245 + 32'd12345;
            trip_raw = (lf[19:17] == 3'd0);
            hs_sel = 3'b001 << (i % 3);
            if (i % 50 == 49) hs_sel = 3'b011;
            cur_req = (i < 150) ? "R3" : "R10";
        end

        // R1 mid-run reset
        cur_req = "R1";
        go(); trip_raw = 0; rst = 1;
        @(negedge clk);
        check("R1", int'(src_en), 0);
        check("R1", int'(hs_gate), 0);
        go(); go(); rst = 0;
        @(negedge clk);
        check("R1", int'(src_en), 1);
        repeat (10) go();
        finish_run();
    end

endmodule